// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Controller

This block is a main-memory front end made of several independent single-port word banks. A flat word address is split into a bank number and a word offset. A parameter picks one of two splits. With low-order interleaving, neighbouring addresses land in neighbouring banks. With high-order interleaving, each bank holds one contiguous slice of the address space.

A single requester issues requests through a valid/ready port. There are three kinds of request: a single-word read, a single-word write, and a burst read of up to sixteen consecutive words, such as a cache-line fill. Read data leaves on a response port that carries a valid flag and a last-word marker, and that port has no backpressure.

Every bank takes one access per cycle at most, and a read keeps its bank occupied for two cycles. The controller sends accesses out one at a time, in address order, and waits whenever the target bank is still occupied. As a result, a low-order burst returns one word per cycle once the first word arrives, while a burst that stays inside one bank returns a word every other cycle.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and both rsp_valid and rsp_last are 0.
- R2: In low-order mode the bank is the address modulo the bank count (the K least significant bits) and the offset is the remaining upper bits. In high-order mode the bank is the K most significant bits of the 6-bit address and the offset is the lower bits.
- R3: A single read (req_op 0) accepted in cycle a, with its bank free, produces exactly one response in cycle a+3. That response has rsp_last=1 and carries the value most recently written to the address.
- R4: A write (req_op 1) stores req_wdata at req_addr in a single cycle and produces no response. Any read issued after it returns the new value.
- R5: A burst read (req_op 2) with length field L returns L+1 words from addresses start, start+1, … modulo 64, in that order. rsp_last is 1 only on the final word.
- R6: req_op 3 behaves as a single read, and the length field is ignored for every op other than 2.
- R7: A read keeps its bank occupied in the cycle after it issues. Across all banks, at most one access issues per cycle, and an access to an occupied bank is held back until that bank is free.
- R8: In low-order mode, a burst read issues one word per cycle. Once the first word arrives, the following words arrive in consecutive cycles.
- R9: In high-order mode, consecutive words in the same bank issue two cycles apart. The first word in the next bank issues in the following cycle.
- R10: In the cycle after any request is accepted, req_ready is 0. It stays 0 until the last word of that request has issued, and a request held valid during that time is not taken.
- R11: rsp_last is never 1 without rsp_valid, and at most one bank returns data in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 burst read, 3 read |
| req_addr | input | 6 | Word address (start address for bursts) |
| req_len | input | 4 | Burst length minus one |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_data | output | 8 | Read data |
| rsp_last | output | 1 | Final word of a request |

## Verification
The bench first fills all 64 words by writing them, then reads each word back on its own. These steps separate data-path faults from mapping faults, because a consistent but wrong mapping still returns correct data. It then sends a burst for every start address and every length, back to back. The arrival cycle of each response shows which bank each word went to: wrap-around at address 63, crossings between banks in high-order mode, and stalls where a new request follows a burst straight into an occupied bank. Finally, writes with a non-zero length field, reads using the spare op code, and writes followed at once by reads of the same bank cover op decoding and the ordering of a write before a later read.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BURST = 2'd2,
    OP_SPARE = 2'd3
  } ilv_op_e;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int AW        = 6,
  parameter int KB        = 2,
  parameter bit LOW_ORDER = 1'b1
) (
  input  logic [AW-1:0]    addr,
  output logic [KB-1:0]    bank,
  output logic [AW-KB-1:0] off
);
  localparam int OW = AW - KB;

  generate
    if (LOW_ORDER) begin : g_low
      function automatic logic [KB-1:0] bank_sel(logic [AW-1:0] a);
        return a[KB-1:0];
      endfunction
      function automatic logic [OW-1:0] word_sel(logic [AW-1:0] a);
        return a[AW-1:KB];
      endfunction
      assign bank = bank_sel(addr);
      assign off  = word_sel(addr);
    end else begin : g_high
      function automatic logic [KB-1:0] bank_sel(logic [AW-1:0] a);
        return a[AW-1:OW];
      endfunction
      function automatic logic [OW-1:0] word_sel(logic [AW-1:0] a);
        return a[OW-1:0];
      endfunction
      assign bank = bank_sel(addr);
      assign off  = word_sel(addr);
    end
  endgenerate
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int OW     = 4,
  parameter int DW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [OW-1:0] acc_off,
  input  logic [DW-1:0] acc_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << OW;
  localparam int BCW   = (RD_LAT > 2) ? $clog2(RD_LAT) : 1;

  logic [DW-1:0]     mem [DEPTH];
  logic              a_v;
  logic [OW-1:0]     a_off;
  logic [RD_LAT-2:0] v_pipe;
  logic [DW-1:0]     d_pipe [RD_LAT-1];
  logic [BCW-1:0]    busy_cnt;

  wire rd_start = acc_en && !acc_we;

  assign busy     = (busy_cnt != '0);
  assign rd_valid = v_pipe[RD_LAT-2];
  assign rd_data  = d_pipe[RD_LAT-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v      <= 1'b0;
      v_pipe   <= '0;
      busy_cnt <= '0;
    end else begin
      a_v       <= rd_start;
      v_pipe[0] <= a_v;
      for (int i = 1; i < RD_LAT - 1; i++) v_pipe[i] <= v_pipe[i-1];
      if (rd_start)      busy_cnt <= BCW'(RD_LAT - 1);
      else if (busy)     busy_cnt <= busy_cnt - BCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) a_off <= acc_off;
    if (acc_en && acc_we) mem[acc_off] <= acc_wdata;
    d_pipe[0] <= mem[a_off];
    for (int i = 1; i < RD_LAT - 1; i++) d_pipe[i] <= d_pipe[i-1];
  end

  // R7: the sequencer never targets a bank that is still occupied
  p_no_access_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> !busy);
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int AW        = 6,
  parameter int KB        = 2,
  parameter int DW        = 8,
  parameter int MAX_BURST = 16,
  parameter int RD_LAT    = 2,
  parameter bit LOW_ORDER = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic [AW-1:0]                 req_addr,
  input  logic [$clog2(MAX_BURST)-1:0]  req_len,
  input  logic [DW-1:0]                 req_wdata,
  input  logic [(1<<KB)-1:0]            bank_busy,
  output logic [(1<<KB)-1:0]            acc_en,
  output logic                          acc_we,
  output logic [AW-KB-1:0]              acc_off,
  output logic [DW-1:0]                 acc_wdata,
  output logic                          rsp_valid,
  output logic                          rsp_last
);
  localparam int NB = 1 << KB;
  localparam int OW = AW - KB;
  localparam int LW = $clog2(MAX_BURST);
  localparam int CW = $clog2(MAX_BURST + 1);

  function automatic logic [CW-1:0] words_of(ilv_op_e op, logic [LW-1:0] len);
    if (op == OP_BURST) return CW'(len) + CW'(1);
    return CW'(1);
  endfunction

  logic [AW-1:0]     cur_addr;
  logic [CW-1:0]     left;
  logic              cur_wr;
  logic [DW-1:0]     cur_wd;
  logic [KB-1:0]     cur_bank;
  logic [OW-1:0]     cur_off;
  logic [RD_LAT-1:0] t_v;
  logic [RD_LAT-1:0] t_last;

  ilv_addr_map #(.AW(AW), .KB(KB), .LOW_ORDER(LOW_ORDER)) u_map (
    .addr (cur_addr),
    .bank (cur_bank),
    .off  (cur_off)
  );

  ilv_op_e op_in;
  assign op_in = ilv_op_e'(req_op);

  wire accept    = req_valid && req_ready;
  wire issue     = (left != '0) && !bank_busy[cur_bank];
  wire last_word = (left == CW'(1));
  wire rd_issue  = issue && !cur_wr;

  assign req_ready = (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left     <= '0;
      cur_wr   <= 1'b0;
      cur_wd   <= '0;
    end else if (accept) begin
      cur_addr <= req_addr;
      left     <= words_of(op_in, req_len);
      cur_wr   <= (op_in == OP_WRITE);
      cur_wd   <= req_wdata;
    end else if (issue) begin
      cur_addr <= cur_addr + AW'(1);
      left     <= left - CW'(1);
    end
  end

  generate
    for (genvar i = 0; i < NB; i++) begin : g_en
      assign acc_en[i] = issue && (cur_bank == KB'(i));
    end
  endgenerate

  assign acc_we    = cur_wr;
  assign acc_off   = cur_off;
  assign acc_wdata = cur_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v    <= '0;
      t_last <= '0;
    end else begin
      t_v    <= {t_v[RD_LAT-2:0], rd_issue};
      t_last <= {t_last[RD_LAT-2:0], rd_issue && last_word};
    end
  end

  assign rsp_valid = t_v[RD_LAT-1];
  assign rsp_last  = t_last[RD_LAT-1];

  // R10: a freshly accepted request blocks the port on the next cycle
  p_ready_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: no more than one bank receives an access in a cycle
  p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_en));
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int AW        = 6,
  parameter int KB        = 2,
  parameter int DW        = 8,
  parameter int MAX_BURST = 16,
  parameter int RD_LAT    = 2,
  parameter bit LOW_ORDER = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [AW-1:0]                req_addr,
  input  logic [$clog2(MAX_BURST)-1:0] req_len,
  input  logic [DW-1:0]                req_wdata,
  output logic                         rsp_valid,
  output logic [DW-1:0]                rsp_data,
  output logic                         rsp_last
);
  localparam int NB = 1 << KB;
  localparam int OW = AW - KB;

  logic [NB-1:0] bank_busy;
  logic [NB-1:0] acc_en;
  logic          acc_we;
  logic [OW-1:0] acc_off;
  logic [DW-1:0] acc_wdata;
  logic [NB-1:0] bank_rv;
  logic [DW-1:0] bank_rd [NB];
  logic [DW-1:0] rd_or;

  ilv_seq #(
    .AW(AW), .KB(KB), .DW(DW), .MAX_BURST(MAX_BURST),
    .RD_LAT(RD_LAT), .LOW_ORDER(LOW_ORDER)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .bank_busy (bank_busy),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_off   (acc_off),
    .acc_wdata (acc_wdata),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last)
  );

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bank
      ilv_bank #(.OW(OW), .DW(DW), .RD_LAT(RD_LAT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en[i]),
        .acc_we    (acc_we),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata),
        .busy      (bank_busy[i]),
        .rd_valid  (bank_rv[i]),
        .rd_data   (bank_rd[i])
      );
    end
  endgenerate

  always_comb begin
    rd_or = '0;
    for (int i = 0; i < NB; i++) begin
      if (bank_rv[i]) rd_or = rd_or | bank_rd[i];
    end
  end

  assign rsp_data = rd_or;

  // R11: returned words never collide on the response bus
  p_single_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_rv));

  // R11: the tag pipe and the banks agree on when a word comes back
  p_tag_agrees_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == (|bank_rv));

  // R5: the last marker only accompanies data
  p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);
endmodule

// File: tb/test_ilv_mem_ctrl.sv
module ilv_bench_core #(
  parameter bit LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   errors
);
  localparam int NB   = 4;
  localparam int CAP  = 64;
  localparam int WPB  = CAP / NB;

  logic       req_valid, req_ready, rsp_valid, rsp_last;
  logic [1:0] req_op;
  logic [5:0] req_addr;
  logic [3:0] req_len;
  logic [7:0] req_wdata, rsp_data;

  ilv_mem_ctrl #(.LOW_ORDER(LOW)) i_ilv_mem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  int         cyc;
  bit         run;
  int         bad_last;
  logic [7:0] shadow [CAP];
  int         bfree [NB];
  int         next_t;
  int         q_cyc[$];
  int         q_dat[$];
  bit         q_last[$];
  string      tag_dat, tag_tim;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int bank_of(int a);
    return LOW ? (a % NB) : (a / WPB);
  endfunction

  function automatic int pat(int a, int s);
    return (a * 29 + s * 71 + (LOW ? 5 : 0)) % 256;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (low=%0d cyc=%0d) actual=%0d expected=%0d", tag, LOW, cyc, act, exp);
    end
  endtask

  task automatic model(int a, int op, int addr, int lenm1, int wd);
    int n, t;
    n = (op == 2) ? lenm1 + 1 : 1;
    t = (a + 1 > next_t) ? a + 1 : next_t;
    for (int i = 0; i < n; i++) begin
      int ad, b;
      ad = (addr + i) % CAP;
      b  = bank_of(ad);
      while (t < bfree[b]) t++;
      if (op == 1) begin
        shadow[ad] = wd[7:0];
        bfree[b]   = t + 1;
      end else begin
        q_cyc.push_back(t + 2);
        q_dat.push_back(int'(shadow[ad]));
        q_last.push_back(i == n - 1);
        bfree[b] = t + 2;
      end
      t++;
    end
    next_t = t;
  endtask

  task automatic send(int op, int addr, int lenm1, int wd);
    req_op    = op[1:0];
    req_addr  = addr[5:0];
    req_len   = lenm1[3:0];
    req_wdata = wd[7:0];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    model(cyc, op, addr, lenm1, wd);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", int'(req_ready), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      if (rsp_last && !rsp_valid) bad_last++;
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        chk(rsp_valid, tag_tim, int'(rsp_valid), 1);
        if (rsp_valid) begin
          chk(int'(rsp_data) == q_dat[0], tag_dat, int'(rsp_data), q_dat[0]);
          chk(rsp_last == q_last[0], "R5", int'(rsp_last), int'(q_last[0]));
        end
        void'(q_cyc.pop_front());
        void'(q_dat.pop_front());
        void'(q_last.pop_front());
      end else if (rsp_valid) begin
        chk(1'b0, tag_tim, 1, 0);
      end
    end
  end

  initial begin
    done = 0; checks = 0; errors = 0; run = 0; bad_last = 0; next_t = 0;
    req_valid = 0; req_op = 0; req_addr = 0; req_len = 0; req_wdata = 0;
    for (int b = 0; b < NB; b++) bfree[b] = 0;
    for (int a = 0; a < CAP; a++) shadow[a] = 8'h00;
    tag_dat = "R3"; tag_tim = "R7";
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    chk(rsp_last == 1'b0, "R1", int'(rsp_last), 0);
    run = 1;

    tag_dat = "R4"; tag_tim = "R4 R7";
    for (int a = 0; a < CAP; a++) send(1, a, 0, pat(a, 1));

    tag_dat = "R3 R4"; tag_tim = "R3 R7";
    for (int a = 0; a < CAP; a++) send(0, a, 0, 0);

    tag_dat = "R6"; tag_tim = "R6 R7";
    for (int a = 0; a < CAP; a += 5) begin
      send(1, a, 15, pat(a, 2));
      send(3, a, 7, 0);
    end

    tag_dat = "R5";
    tag_tim = LOW ? "R2 R8" : "R2 R9";
    for (int s = 0; s < CAP; s++)
      for (int l = 0; l < 16; l++) send(2, s, l, 0);

    tag_dat = "R4 R5"; tag_tim = "R4 R7";
    for (int a = 0; a < CAP; a += 3) begin
      send(1, a, 0, pat(a, 3));
      send(2, a, 3, 0);
      send(0, (a + 1) % CAP, 0, 0);
    end

    repeat (40) @(negedge clk);
    chk(q_cyc.size() == 0, "R5", q_cyc.size(), 0);
    chk(bad_last == 0, "R11", bad_last, 0);
    done = 1;
  end
endmodule

module test_ilv_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_lo, d_hi;
  int   c_lo, c_hi, e_lo, e_hi;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ilv_bench_core #(.LOW(1'b1)) u_lo (.clk(clk), .rst_n(rst_n), .done(d_lo), .checks(c_lo), .errors(e_lo));
  ilv_bench_core #(.LOW(1'b0)) u_hi (.clk(clk), .rst_n(rst_n), .done(d_hi), .checks(c_hi), .errors(e_hi));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int n;
    int wd;
    n  = 0;
    wd = 0;
    while (!(d_lo === 1'b1 && d_hi === 1'b1) && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!(d_lo === 1'b1 && d_hi === 1'b1)) begin
      wd = 1;
      $display("FAIL watchdog expired after %0d cycles, expected completion", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", c_lo + c_hi + wd, e_lo + e_hi + wd);
    $finish;
  end
endmodule